// File: doc/BRIEF.md
# Flash Write-Permission and Status Keeper

This block holds the status byte of a serial flash device and rules on every write request aimed at the array. The command decoder in front of it delivers one-cycle strobes for write-enable, write-disable, status write, byte program, sector erase, block erase and chip erase, together with a 20-bit target address. The block answers each program or erase strobe with a one-cycle `grant` or `deny` pulse. On a grant it also gives the aligned base address that the array engine should work on. The engine reports completion with `op_done`.

Protection follows a 3-bit code. The protected region grows down from the top block: the top sixteenth, eighth, quarter or half of the array, or all of it. A lock bit combined with the active-low write-protect pin freezes the protection code and the lock bit itself. Requests are checked against the write-enable latch, the busy flag, the protected region and, for chip erase, a protection code of zero.

Top module: `flash_guard`

## Requirements
- R1: After reset `status` reads 0x00, and `grant` and `deny` are low. Status layout: bit0 busy, bit1 write-enable latch, bits 4:2 protection code (bit2 is the LSB), bits 6:5 zero, bit7 lock.
- R2: When not busy, `cmd_wren` sets status bit1 and `cmd_wrdi` clears it. The new value is visible the cycle after the strobe.
- R3: A program or erase strobe while the write-enable latch is clear gives a `deny` pulse the next cycle and leaves `status` unchanged.
- R4: The protection code k covers these blocks (block = address bits 19:16): k=0 none; k=1 block 15; k=2 blocks 14-15; k=3 blocks 12-15; k=4 blocks 8-15; k=5,6,7 all 16 blocks.
- R5: A program, sector erase or block erase whose address is in a protected block is denied. The write-enable latch is cleared and busy stays 0.
- R6: Chip erase is denied when the protection code is nonzero, and clears the write-enable latch. It is granted when the code is 0 and the latch is set.
- R7: An accepted request pulses `grant` the next cycle and sets busy. `op_base` then holds the full address for a program, the address with bits 11:0 cleared for a sector erase, the address with bits 15:0 cleared for a block erase, and 0 for a chip erase.
- R8: While busy, every strobe leaves `status` unchanged, and program or erase strobes are denied. Only `op_done` acts.
- R9: `op_done` while busy clears busy and the write-enable latch the next cycle. `op_done` while idle has no effect.
- R10: `cmd_wrsr` with the latch set and no lock in force loads `new_bp` into bits 4:2 and `new_lock` into bit7, and clears the latch. With the latch clear it has no effect.
- R11: When bit7 is 1 and `wp_n` is 0, `cmd_wrsr` leaves bits 7:2 unchanged but still clears the latch. With `wp_n` at 1, the lock bit does not block the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| new_bp | input | 3 | Protection code carried by a status write |
| new_lock | input | 1 | Lock bit carried by a status write |
| cmd_prog | input | 1 | Byte-program request |
| cmd_sect | input | 1 | Sector-erase request |
| cmd_blk | input | 1 | Block-erase request |
| cmd_chip | input | 1 | Chip-erase request |
| req_addr | input | 20 | Target byte address |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array engine reports end of operation |
| status | output | 8 | Status byte |
| grant | output | 1 | Request accepted pulse |
| deny | output | 1 | Request refused pulse |
| op_base | output | 20 | Aligned start address of the granted operation |

## Verification
The table walk sets each protection code from 0 to 7. It then aims program, sector, block and chip requests at the block just inside and the block just outside the protected boundary, so that an off-by-one in the region compare shows as a wrong grant. Addresses with nonzero low bits tell the three alignment widths apart in `op_base`. Directed sequences cover the remaining cases: a request with the latch clear, strobes that arrive while busy, `op_done` while idle, and status writes under each combination of lock bit and pin. These separate the write-enable gating from the protection gating.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;

  localparam int ST_BUSY   = 0;
  localparam int ST_WEL    = 1;
  localparam int ST_BP_LSB = 2;
  localparam int ST_LOCK   = 7;
endpackage

// File: rtl/flash_guard_region.sv
module flash_guard_region #(
  parameter int BLK_W = 4,
  parameter int BP_W  = 3
) (
  input  logic [BP_W-1:0]  bp,
  input  logic [BLK_W-1:0] blk,
  output logic             hit
);
  localparam int NBLK = 1 << BLK_W;

  logic [BLK_W:0]    span;
  logic [NBLK-1:0]   prot_vec;

  // number of protected blocks counted down from the top
  always_comb begin
    if (bp == '0)
      span = '0;
    else if (int'(bp) > BLK_W)
      span = (BLK_W+1)'(NBLK);
    else
      span = (BLK_W+1)'(1) << (bp - BP_W'(1));
  end

  genvar b;
  generate
    for (b = 0; b < NBLK; b++) begin : g_blk
      assign prot_vec[b] = ((BLK_W+1)'(b) + span) >= (BLK_W+1)'(NBLK);
    end
  endgenerate

  assign hit = prot_vec[blk];
endmodule

// File: rtl/flash_guard_align.sv
module flash_guard_align
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 12,
  parameter int BLK_LSB  = 16
) (
  input  op_kind_e          kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

  always_comb begin
    unique case (kind)
      OP_PROG: base = addr;
      OP_SECT: base = addr & SECT_MASK;
      OP_BLK:  base = addr & BLK_MASK;
      default: base = '0;
    endcase
  end
endmodule

// File: rtl/flash_guard_status.sv
module flash_guard_status #(
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            rst_ok,
  input  logic            set_busy,
  input  logic            clr_busy,
  input  logic            set_wel,
  input  logic            clr_wel,
  input  logic            ld_sr,
  input  logic [BP_W-1:0] sr_bp,
  input  logic            sr_lock,
  output logic            busy_q,
  output logic            wel_q,
  output logic [BP_W-1:0] bp_q,
  output logic            lock_q
);
  logic            busy_d, wel_d, lock_d;
  logic [BP_W-1:0] bp_d;
  logic            busy_en, wel_en;

  always_comb begin
    busy_en = set_busy | clr_busy;
    busy_d  = set_busy;
    wel_en  = set_wel | clr_wel;
    wel_d   = set_wel & ~clr_wel;
    bp_d    = sr_bp;
    lock_d  = sr_lock;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      bp_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (wel_en)  wel_q  <= wel_d;
      if (ld_sr) begin
        bp_q   <= bp_d;
        lock_q <= lock_d;
      end
    end
  end

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    busy_q && clr_busy |=> !busy_q && !wel_q);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BLK_W    = 4,
  parameter int SECT_LSB = 12,
  parameter int BP_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [BP_W-1:0]   new_bp,
  input  logic              new_lock,
  input  logic              cmd_prog,
  input  logic              cmd_sect,
  input  logic              cmd_blk,
  input  logic              cmd_chip,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status,
  output logic              grant,
  output logic              deny,
  output logic [ADDR_W-1:0] op_base
);
  localparam int BLK_LSB = ADDR_W - BLK_W;

  logic [1:0]        rst_sync;
  logic              rst_ok;
  logic              busy, wel, lock;
  logic [BP_W-1:0]   bp;
  logic              is_req, idle, locked, in_prot, refused, accept;
  op_kind_e          kind;
  logic [ADDR_W-1:0] base_c;
  logic              set_busy, clr_busy, set_wel, clr_wel, ld_sr;
  logic              grant_d, deny_d;
  logic [ADDR_W-1:0] base_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  flash_guard_region #(.BLK_W(BLK_W), .BP_W(BP_W)) u_region (
    .bp  (bp),
    .blk (req_addr[ADDR_W-1:BLK_LSB]),
    .hit (in_prot)
  );

  flash_guard_align #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)) u_align (
    .kind (kind),
    .addr (req_addr),
    .base (base_c)
  );

  flash_guard_status #(.BP_W(BP_W)) u_status (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .set_busy (set_busy),
    .clr_busy (clr_busy),
    .set_wel  (set_wel),
    .clr_wel  (clr_wel),
    .ld_sr    (ld_sr),
    .sr_bp    (new_bp),
    .sr_lock  (new_lock),
    .busy_q   (busy),
    .wel_q    (wel),
    .bp_q     (bp),
    .lock_q   (lock)
  );

  // request decode and permission decision
  always_comb begin
    if (cmd_chip)      kind = OP_CHIP;
    else if (cmd_blk)  kind = OP_BLK;
    else if (cmd_sect) kind = OP_SECT;
    else               kind = OP_PROG;
    is_req   = cmd_prog | cmd_sect | cmd_blk | cmd_chip;
    idle     = ~busy;
    locked   = lock & ~wp_n;
    refused  = (kind == OP_CHIP) ? (bp != '0) : in_prot;
    accept   = is_req & idle & wel & ~refused;
    set_busy = accept;
    clr_busy = busy & op_done;
    set_wel  = idle & cmd_wren;
    clr_wel  = clr_busy
             | (idle & (cmd_wrdi | (cmd_wrsr & wel) | (is_req & wel & refused)));
    ld_sr    = idle & cmd_wrsr & wel & ~locked;
    grant_d  = accept;
    deny_d   = is_req & ~accept;
    base_d   = accept ? base_c : op_base;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      grant   <= 1'b0;
      deny    <= 1'b0;
      op_base <= '0;
    end else begin
      grant   <= grant_d;
      deny    <= deny_d;
      op_base <= base_d;
    end
  end

  assign status = {lock, 2'b00, bp, wel, busy};

  // R3
  no_wel_deny_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    is_req && !status[ST_WEL] |=> deny && !grant && $stable(status));
  // R7
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    grant |-> status[ST_BUSY] && !deny);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    status[ST_BUSY] && !op_done |=> status[ST_BUSY] && $stable(status));
  // R6
  chip_code_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmd_chip && status[4:2] != 3'b000 |=> deny);
  // R11
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cmd_wrsr && status[ST_LOCK] && !wp_n |=> $stable(status[7:2]));
  // R5
  prot_one_req_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({cmd_prog, cmd_sect, cmd_blk, cmd_chip}));
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wren, cmd_wrdi, cmd_wrsr, new_lock;
  logic [2:0]  new_bp;
  logic        cmd_prog, cmd_sect, cmd_blk, cmd_chip;
  logic [19:0] req_addr;
  logic        wp_n, op_done;
  logic [7:0]  status;
  logic        grant, deny;
  logic [19:0] op_base;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .new_bp(new_bp), .new_lock(new_lock),
    .cmd_prog(cmd_prog), .cmd_sect(cmd_sect), .cmd_blk(cmd_blk),
    .cmd_chip(cmd_chip), .req_addr(req_addr), .wp_n(wp_n), .op_done(op_done),
    .status(status), .grant(grant), .deny(deny), .op_base(op_base)
  );

  // command codes local to the bench
  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROG = 3,
                 C_SECT = 4, C_BLK = 5, C_CHIP = 6, C_DONE = 7, C_NONE = 8;

  // {code[2:0], addr[19:0], kind[1:0] 0=prog 1=sect 2=blk 3=chip, grant, base[19:0]}
  localparam int NV = 14;
  localparam logic [45:0] VEC [NV] = '{
    {3'd0, 20'hFFFFF, 2'd0, 1'b1, 20'hFFFFF},
    {3'd1, 20'hF0000, 2'd1, 1'b0, 20'h00000},
    {3'd1, 20'hEFFFF, 2'd0, 1'b1, 20'hEFFFF},
    {3'd2, 20'hE1234, 2'd1, 1'b0, 20'h00000},
    {3'd2, 20'hDFFFF, 2'd2, 1'b1, 20'hD0000},
    {3'd3, 20'hC5678, 2'd0, 1'b0, 20'h00000},
    {3'd3, 20'hBABCD, 2'd1, 1'b1, 20'hBA000},
    {3'd4, 20'h80000, 2'd2, 1'b0, 20'h00000},
    {3'd4, 20'h7F123, 2'd2, 1'b1, 20'h70000},
    {3'd5, 20'h00000, 2'd0, 1'b0, 20'h00000},
    {3'd7, 20'h12345, 2'd1, 1'b0, 20'h00000},
    {3'd0, 20'h12345, 2'd3, 1'b1, 20'h00000},
    {3'd1, 20'h12345, 2'd3, 1'b0, 20'h00000},
    {3'd0, 20'h3C789, 2'd1, 1'b1, 20'h3C000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one strobe at a falling edge, return at the next falling edge
  task automatic cmd(input int c, input logic [19:0] a = '0,
                     input logic [2:0] b = '0, input logic l = 1'b0);
    req_addr = a; new_bp = b; new_lock = l;
    cmd_wren = (c == C_WREN); cmd_wrdi = (c == C_WRDI); cmd_wrsr = (c == C_WRSR);
    cmd_prog = (c == C_PROG); cmd_sect = (c == C_SECT); cmd_blk = (c == C_BLK);
    cmd_chip = (c == C_CHIP); op_done = (c == C_DONE);
    @(posedge clk);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_sect, cmd_blk, cmd_chip, op_done} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; req_addr = '0; new_bp = '0; new_lock = 1'b0;
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_sect, cmd_blk, cmd_chip, op_done} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 grant/deny", {grant, deny}, 2'b00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  v_bp   = VEC[i][45:43];
      logic [19:0] v_addr = VEC[i][42:23];
      logic [1:0]  v_kind = VEC[i][22:21];
      logic        v_g    = VEC[i][20];
      logic [19:0] v_base = VEC[i][19:0];
      cmd(C_WREN);
      cmd(C_WRSR, '0, v_bp, 1'b0);
      chk("R10 code load", status, {3'b000, v_bp, 2'b00});
      cmd(C_WREN);
      chk("R2 latch set", status, {3'b000, v_bp, 2'b10});
      cmd(C_PROG + int'(v_kind), v_addr);
      chk("R4 R6 grant", {grant, deny}, {v_g, ~v_g});
      if (v_g) begin
        chk("R7 base", op_base, v_base);
        chk("R7 busy", status, {3'b000, v_bp, 2'b11});
        cmd(C_DONE);
        chk("R9 done clears", status, {3'b000, v_bp, 2'b00});
      end else begin
        chk("R5 latch cleared", status, {3'b000, v_bp, 2'b00});
      end
    end

    // R3 request without latch
    cmd(C_WREN); cmd(C_WRSR, '0, 3'd0, 1'b0);
    cmd(C_PROG, 20'h00010);
    chk("R3 deny no latch", {grant, deny}, 2'b01);
    chk("R3 status kept", status, 8'h00);

    // R2 disable
    cmd(C_WREN); cmd(C_WRDI);
    chk("R2 latch clear", status, 8'h00);

    // R8 strobes while busy
    cmd(C_WREN); cmd(C_SECT, 20'h01234);
    chk("R7 sector grant", {grant, op_base}, {1'b1, 20'h01000});
    cmd(C_WRDI);
    chk("R8 wrdi ignored", status, 8'h03);
    cmd(C_WRSR, '0, 3'd7, 1'b1);
    chk("R8 wrsr ignored", status, 8'h03);
    cmd(C_PROG, 20'h00020);
    chk("R8 busy deny", {grant, deny, status}, {2'b01, 8'h03});
    cmd(C_DONE);
    chk("R9 done", status, 8'h00);
    cmd(C_DONE);
    chk("R9 idle done no effect", status, 8'h00);
    cmd(C_WREN); cmd(C_DONE);
    chk("R9 idle done keeps latch", status, 8'h02);

    // R10 status write without latch
    cmd(C_WRDI); cmd(C_WRSR, '0, 3'd3, 1'b1);
    chk("R10 no latch no write", status, 8'h00);

    // R11 lock behaviour
    cmd(C_WREN); cmd(C_WRSR, '0, 3'd1, 1'b1);
    chk("R10 lock load", status, 8'h84);
    wp_n = 1'b0;
    cmd(C_WREN); cmd(C_WRSR, '0, 3'd0, 1'b0);
    chk("R11 locked write", status, 8'h84);
    wp_n = 1'b1;
    cmd(C_WREN); cmd(C_WRSR, '0, 3'd0, 1'b0);
    chk("R11 pin high unlocks", status, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule